// File: doc/BRIEF.md
# Serial-Programmed Parallel Flash Bus Bridge

This bridge lets a host with only three serial wires (a data bit, a bit clock and an active-low framing strobe) operate a parallel flash memory. Each frame starts by pulling the strobe low and clocking in a 3-bit register number. After the strobe rises, further clock pulses shift bits into that register. The registers are three address fragments, one data byte and one control word. The address bus always presents the three fragments joined together. The control word reaches the flash pins only when the host gives a strobe pulse that carries no clock pulses. That pulse is the "apply" event, and it lets the host step the chip-select, write and read pins through a bus cycle one phase at a time.

On a read, the apply that releases the read pin also captures the flash data bus into the data register. The host then selects the data register and clocks the captured byte out on the serial output, least significant bit first. While the park input is high, every flash-side pin is released to high impedance through its output-enable, and all serial activity is ignored. The serial inputs are synchronised to the system clock, so the host's serial clock may be slow and unrelated to it.

Top module: `flash_serial_bridge`

## Requirements
- R1: With the strobe low, exactly three serial clock pulses select a register, LSB first. The codes are 000 = data byte, 001 = address bits 3:0, 010 = address bits 7:4, 011 = address bits 17:8 and 111 = control word. Any other code selects nothing, so the pulses that follow change no register.
- R2: After a valid selection and with the strobe high, each serial clock pulse shifts `ser_din` into the selected register LSB first. After W pulses, the first bit sent sits in bit 0. Pulses beyond the register width W are ignored.
- R3: If the strobe rises after one, two, or four or more selection pulses, the frame is discarded and later pulses change no register.
- R4: `addr_o` always equals {fragment 011, fragment 010, fragment 001}. Each fragment keeps its value until it is loaded again, so a host may reload only the fragments that changed.
- R5: The control word is {drive, cs, wr, rd} in bits 3..0, each active low, shifted rd first. Loading it leaves the pins unchanged. A strobe pulse with no clock pulses copies cs, wr and rd onto `ce_n_o`, `we_n_o` and `oe_n_o`, and copies drive onto the internal drive pin.
- R6: `data_oe` is 1 only when the applied drive bit is 0 and park is low. `data_o` always shows the data register.
- R7: An apply that moves `oe_n_o` from 0 to 1 loads `data_i` into the data register.
- R8: With the data register selected, `ser_dout` shows bit n of the byte held at selection after the (n+1)th pulse. The bits shifted in at the same time replace the byte, LSB first.
- R9: While `park` is 1, `addr_oe`, `pins_oe` and `data_oe` are 0, the pins and the control word return to 1111, and serial frames are ignored. The address and data registers are retained.
- R10: After the asynchronous reset, the pins are 1111, and the address, data and `ser_dout` are 0.
- R11: If park is high in the same cycle that an apply is recognised, park wins: the pins stay at 1111 and the control word is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| park | input | 1 | Releases all flash-side pins and freezes the serial side |
| ser_clk | input | 1 | Serial bit clock, acted on at its rising edge |
| ser_din | input | 1 | Serial data in |
| ser_ctrl_n | input | 1 | Active-low frame strobe |
| ser_dout | output | 1 | Serial read-out bit |
| addr_o | output | ADDR_W | Flash address |
| addr_oe | output | 1 | Output enable for the address pins |
| data_o | output | DATA_W | Data register toward the flash |
| data_i | input | DATA_W | Flash data bus as seen at the pads |
| data_oe | output | 1 | Output enable for the data pins |
| ce_n_o | output | 1 | Flash chip select, active low |
| we_n_o | output | 1 | Flash write strobe, active low |
| oe_n_o | output | 1 | Flash read strobe, active low |
| pins_oe | output | 1 | Output enable for the three control pins |

## Verification
Park and the apply event can land in the same system cycle. The bench provokes this by raising the strobe on a plain apply pulse and then raising park for one cycle, timed to the cycle in which the synchronised strobe edge is acted on. It judges the outcome at the ports: the pins must remain 1111 with the data bus released, and a later clean apply must still give 1111, which shows that the pending control word was discarded. The park path is also exercised on its own, with a driven write phase in progress and a full frame sent while parked.

// File: rtl/flashbr_pkg.sv
package flashbr_pkg;

   typedef enum logic [1:0] {
      FR_IDLE   = 2'd0,
      FR_SELECT = 2'd1,
      FR_LOAD   = 2'd2
   } frame_st_e;

   localparam int SEL_W = 3;

   localparam logic [SEL_W-1:0] SEL_DATA = 3'b000;
   localparam logic [SEL_W-1:0] SEL_ALO  = 3'b001;
   localparam logic [SEL_W-1:0] SEL_CTRL = 3'b111;

   localparam int CW_W   = 4;
   localparam int CW_RD  = 0;
   localparam int CW_WR  = 1;
   localparam int CW_CS  = 2;
   localparam int CW_DRV = 3;

   localparam logic [CW_W-1:0] CW_IDLE = 4'b1111;

   function automatic int max_of3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/flashbr_sync.sv
module flashbr_sync #(
   parameter int               W       = 3,
   parameter int               STAGES  = 2,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg <= {stg[STAGES-2:0], d};
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/flashbr_field.sv
module flashbr_field #(
   parameter int           W       = 4,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         shift,
   input  logic         din,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_VAL;
      end else if (clr) begin
         q <= RST_VAL;
      end else if (ld) begin
         q <= ld_val;
      end else if (shift) begin
         q <= {din, q[W-1:1]};
      end
   end

endmodule

// File: rtl/flashbr_frame.sv
module flashbr_frame
   import flashbr_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             park,
   input  logic             clk_rise,
   input  logic             ctrl_fall,
   input  logic             ctrl_rise,
   input  logic             din,
   output logic [SEL_W-1:0] sel,
   output logic [IDX_W-1:0] idx,
   output logic             shift_go,
   output logic             apply_go,
   output logic             in_load
);

   frame_st_e        st;
   logic [2:0]       cnt;
   logic [SEL_W-1:0] sel_sh;

   always_comb begin
      apply_go = (st == FR_SELECT) && ctrl_rise && (cnt == 3'd0) && !park;
      shift_go = (st == FR_LOAD) && clk_rise && !ctrl_fall && !park;
      in_load  = (st == FR_LOAD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= FR_IDLE;
         cnt    <= '0;
         sel_sh <= '0;
         sel    <= '0;
         idx    <= '0;
      end else if (park) begin
         st  <= FR_IDLE;
         cnt <= '0;
      end else if (ctrl_fall) begin
         st     <= FR_SELECT;
         cnt    <= '0;
         sel_sh <= '0;
      end else begin
         case (st)
            FR_SELECT: begin
               if (ctrl_rise) begin
                  if (cnt == 3'd3) begin
                     sel <= sel_sh;
                     idx <= '0;
                     st  <= FR_LOAD;
                  end else begin
                     st  <= FR_IDLE;
                  end
               end else if (clk_rise && (cnt != 3'd4)) begin
                  if (cnt < 3'd3) begin
                     sel_sh[cnt[1:0]] <= din;
                  end
                  cnt <= cnt + 3'd1;
               end
            end
            FR_LOAD: begin
               if (clk_rise && (idx != '1)) begin
                  idx <= idx + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/flash_serial_bridge.sv
module flash_serial_bridge
   import flashbr_pkg::*;
#(
   parameter int ADDR_W      = 18,
   parameter int DATA_W      = 8,
   parameter int LO_W        = 4,
   parameter int MID_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              park,
   input  logic              ser_clk,
   input  logic              ser_din,
   input  logic              ser_ctrl_n,
   output logic              ser_dout,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_oe,
   output logic [DATA_W-1:0] data_o,
   input  logic [DATA_W-1:0] data_i,
   output logic              data_oe,
   output logic              ce_n_o,
   output logic              we_n_o,
   output logic              oe_n_o,
   output logic              pins_oe
);

   localparam int HI_W  = ADDR_W - LO_W - MID_W;
   localparam int MAX_W = max_of3(DATA_W, HI_W, max_of3(LO_W, MID_W, CW_W));
   localparam int IDX_W = $clog2(MAX_W + 1);

   // configuration checks
   if (HI_W < 2 || LO_W < 2 || MID_W < 2 || DATA_W < 2) begin : g_bad_width
      $error("flash_serial_bridge: every register field needs at least 2 bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("flash_serial_bridge: SYNC_STAGES must be 2 or more");
   end

   // input synchronisation and edge detection
   logic [2:0] ser_s;
   logic       sclk_s, sctl_s, sdin_s;
   logic       sclk_d, sctl_d;
   logic       clk_rise, ctrl_fall, ctrl_rise;

   flashbr_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_din, ser_ctrl_n, ser_clk}),
      .q     (ser_s)
   );

   assign sclk_s = ser_s[0];
   assign sctl_s = ser_s[1];
   assign sdin_s = ser_s[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         sctl_d <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         sctl_d <= sctl_s;
      end
   end

   assign clk_rise  =  sclk_s & ~sclk_d;
   assign ctrl_fall = ~sctl_s &  sctl_d;
   assign ctrl_rise =  sctl_s & ~sctl_d;

   // frame sequencing
   logic [SEL_W-1:0] sel;
   logic [IDX_W-1:0] idx;
   logic             shift_go, apply_go, in_load;

   flashbr_frame #(
      .IDX_W (IDX_W)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .park      (park),
      .clk_rise  (clk_rise),
      .ctrl_fall (ctrl_fall),
      .ctrl_rise (ctrl_rise),
      .din       (sdin_s),
      .sel       (sel),
      .idx       (idx),
      .shift_go  (shift_go),
      .apply_go  (apply_go),
      .in_load   (in_load)
   );

   // width of the selected field; zero for unused codes
   logic [IDX_W-1:0] fw;
   always_comb begin
      case (sel)
         3'b000:  fw = IDX_W'(DATA_W);
         3'b001:  fw = IDX_W'(LO_W);
         3'b010:  fw = IDX_W'(MID_W);
         3'b011:  fw = IDX_W'(HI_W);
         3'b111:  fw = IDX_W'(CW_W);
         default: fw = '0;
      endcase
   end

   logic shift_ok;
   assign shift_ok = shift_go && (idx < fw);

   // address fragments
   logic [ADDR_W-1:0] addr_q;

   for (genvar g = 0; g < 3; g++) begin : g_frag
      localparam int FW  = (g == 0) ? LO_W : (g == 1) ? MID_W : HI_W;
      localparam int OFF = (g == 0) ? 0    : (g == 1) ? LO_W  : LO_W + MID_W;
      localparam logic [SEL_W-1:0] CODE = SEL_ALO + SEL_W'(g);

      logic [FW-1:0] frag_q;

      flashbr_field #(
         .W       (FW),
         .RST_VAL ('0)
      ) u_frag (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (1'b0),
         .ld     (1'b0),
         .ld_val ('0),
         .shift  (shift_ok && (sel == CODE)),
         .din    (sdin_s),
         .q      (frag_q)
      );

      assign addr_q[OFF +: FW] = frag_q;
   end

   // control word and applied pins
   logic [CW_W-1:0] ctl_q;
   logic [CW_W-1:0] pins_q;

   flashbr_field #(
      .W       (CW_W),
      .RST_VAL (CW_IDLE)
   ) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (park),
      .ld     (1'b0),
      .ld_val ('0),
      .shift  (shift_ok && (sel == SEL_CTRL)),
      .din    (sdin_s),
      .q      (ctl_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pins_q <= CW_IDLE;
      end else if (park) begin
         pins_q <= CW_IDLE;
      end else if (apply_go) begin
         pins_q <= ctl_q;
      end
   end

   // data register: read capture and serial read-out
   logic              data_shift;
   logic              data_cap;
   logic [DATA_W-1:0] data_q;
   logic              dout_q;

   assign data_shift = shift_ok && (sel == SEL_DATA);
   assign data_cap   = apply_go && !pins_q[CW_RD] && ctl_q[CW_RD];

   flashbr_field #(
      .W       (DATA_W),
      .RST_VAL ('0)
   ) u_data (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (1'b0),
      .ld     (data_cap),
      .ld_val (data_i),
      .shift  (data_shift),
      .din    (sdin_s),
      .q      (data_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= 1'b0;
      end else if (data_shift) begin
         dout_q <= data_q[0];
      end
   end

   // outputs
   assign ser_dout = dout_q;
   assign addr_o   = addr_q;
   assign addr_oe  = !park;
   assign pins_oe  = !park;
   assign data_o   = data_q;
   assign data_oe  = !park && !pins_q[CW_DRV];
   assign ce_n_o   = pins_q[CW_CS];
   assign we_n_o   = pins_q[CW_WR];
   assign oe_n_o   = pins_q[CW_RD];

endmodule

// File: rtl/flashbr_chk.sv
module flashbr_chk #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              park,
   input logic              apply_go,
   input logic              in_load,
   input logic              data_shift,
   input logic              ser_dout,
   input logic [ADDR_W-1:0] addr_o,
   input logic [DATA_W-1:0] data_o,
   input logic [DATA_W-1:0] data_i,
   input logic              data_oe,
   input logic              ce_n_o,
   input logic              we_n_o,
   input logic              oe_n_o
);

   // R9
   park_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      park |=> (ce_n_o && we_n_o && oe_n_o && !data_oe));

   // R5
   pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!apply_go && !park) |=> $stable({ce_n_o, we_n_o, oe_n_o}));

   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_load |=> $stable(addr_o));

   // R8
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !data_shift |=> $stable(ser_dout));

   // R7
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(oe_n_o) && !$past(park)) |-> (data_o == $past(data_i)));

   // R6
   drive_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe && !$past(data_oe)) |-> $past(apply_go));

endmodule

bind flash_serial_bridge flashbr_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .park       (park),
   .apply_go   (apply_go),
   .in_load    (in_load),
   .data_shift (data_shift),
   .ser_dout   (ser_dout),
   .addr_o     (addr_o),
   .data_o     (data_o),
   .data_i     (data_i),
   .data_oe    (data_oe),
   .ce_n_o     (ce_n_o),
   .we_n_o     (we_n_o),
   .oe_n_o     (oe_n_o)
);

// File: tb/flash_serial_bridge_bench.sv
module flash_serial_bridge_bench;

   localparam int HALF = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        park = 1'b1;
   logic        ser_clk = 1'b0;
   logic        ser_din = 1'b0;
   logic        ser_ctrl_n = 1'b1;
   logic        ser_dout;
   logic [17:0] addr_o;
   logic        addr_oe;
   logic [7:0]  data_o;
   logic [7:0]  data_i = 8'h00;
   logic        data_oe;
   logic        ce_n_o, we_n_o, oe_n_o, pins_oe;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   flash_serial_bridge u_flash_serial_bridge (
      .clk        (clk),
      .rst_n      (rst_n),
      .park       (park),
      .ser_clk    (ser_clk),
      .ser_din    (ser_din),
      .ser_ctrl_n (ser_ctrl_n),
      .ser_dout   (ser_dout),
      .addr_o     (addr_o),
      .addr_oe    (addr_oe),
      .data_o     (data_o),
      .data_i     (data_i),
      .data_oe    (data_oe),
      .ce_n_o     (ce_n_o),
      .we_n_o     (we_n_o),
      .oe_n_o     (oe_n_o),
      .pins_oe    (pins_oe)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ser_bit(input logic b);
      ser_din = b;
      settle(HALF);
      ser_clk = 1'b1;
      settle(HALF);
      ser_clk = 1'b0;
      settle(HALF);
   endtask

   task automatic strobe_low();
      ser_ctrl_n = 1'b0;
      settle(HALF);
   endtask

   task automatic strobe_high();
      ser_ctrl_n = 1'b1;
      settle(HALF);
   endtask

   task automatic send(input logic [31:0] v, input int n);
      for (int i = 0; i < n; i++) ser_bit(v[i]);
   endtask

   task automatic pick(input logic [2:0] code);
      strobe_low();
      send({29'd0, code}, 3);
      strobe_high();
   endtask

   task automatic load(input logic [2:0] code, input logic [31:0] v, input int n);
      pick(code);
      send(v, n);
   endtask

   task automatic apply_cw();
      strobe_low();
      strobe_high();
   endtask

   task automatic set_cw(input logic [3:0] cw);
      load(3'b111, {28'd0, cw}, 4);
      apply_cw();
   endtask

   task automatic set_addr(input logic [17:0] a);
      load(3'b001, {28'd0, a[3:0]}, 4);
      load(3'b010, {28'd0, a[7:4]}, 4);
      load(3'b011, {22'd0, a[17:8]}, 10);
   endtask

   function automatic logic [2:0] pins();
      return {ce_n_o, we_n_o, oe_n_o};
   endfunction

   task automatic t_reset();
      settle(4);
      chk("R10 pins after reset", {29'd0, pins()}, 32'h7);
      chk("R10 ser_dout after reset", {31'd0, ser_dout}, 32'h0);
      chk("R10 address after reset", {14'd0, addr_o}, 32'h0);
      chk("R9 address released while parked", {31'd0, addr_oe}, 32'h0);
      chk("R9 pins released while parked", {31'd0, pins_oe}, 32'h0);
      rst_n = 1'b1;
      settle(4);
      park = 1'b0;
      settle(4);
      chk("R9 address driven after park release", {31'd0, addr_oe}, 32'h1);
      chk("R9 pins driven after park release", {31'd0, pins_oe}, 32'h1);
   endtask

   task automatic t_write();
      set_addr(18'h12345);
      chk("R1 R4 address assembled", {14'd0, addr_o}, 32'h12345);
      load(3'b000, 32'hAA, 8);
      load(3'b111, 32'h3, 4);
      chk("R5 load without apply keeps pins", {29'd0, pins()}, 32'h7);
      chk("R5 load without apply keeps bus released", {31'd0, data_oe}, 32'h0);
      apply_cw();
      chk("R5 drive+cs applied", {29'd0, pins()}, 32'h3);
      chk("R6 data bus driven", {31'd0, data_oe}, 32'h1);
      chk("R6 data byte on bus", {24'd0, data_o}, 32'hAA);
      set_cw(4'b0001);
      chk("R5 write strobe asserted", {29'd0, pins()}, 32'h1);
      set_cw(4'b0011);
      chk("R5 write strobe released", {29'd0, pins()}, 32'h3);
      set_cw(4'b1111);
      chk("R6 bus released at idle", {31'd0, data_oe}, 32'h0);
      chk("R5 pins idle", {29'd0, pins()}, 32'h7);
   endtask

   task automatic t_partial();
      load(3'b010, 32'h9, 4);
      chk("R4 only middle fragment reloaded", {14'd0, addr_o}, 32'h12395);
      load(3'b001, 32'h36, 6);
      chk("R2 pulses beyond width ignored", {14'd0, addr_o}, 32'h12396);
   endtask

   task automatic t_bad();
      strobe_low();
      ser_bit(1'b1);
      ser_bit(1'b0);
      strobe_high();
      send(32'h3FF, 10);
      chk("R3 two-pulse selection discarded", {14'd0, addr_o}, 32'h12396);
      strobe_low();
      send(32'h9, 4);
      strobe_high();
      send(32'h3FF, 10);
      chk("R3 four-pulse selection discarded", {14'd0, addr_o}, 32'h12396);
      load(3'b101, 32'h3FF, 10);
      chk("R1 unused code changes nothing", {14'd0, addr_o}, 32'h12396);
      chk("R1 unused code leaves pins", {29'd0, pins()}, 32'h7);
   endtask

   task automatic t_read();
      logic [7:0] got;
      data_i = 8'hC3;
      set_cw(4'b0010);
      chk("R5 read strobe asserted", {31'd0, oe_n_o}, 32'h0);
      set_cw(4'b1010);
      chk("R6 drive released during read", {31'd0, data_oe}, 32'h0);
      set_cw(4'b1111);
      data_i = 8'h00;
      chk("R7 read data captured", {24'd0, data_o}, 32'hC3);
      pick(3'b000);
      got = '0;
      for (int i = 0; i < 8; i++) begin
         ser_bit(logic'((8'h5A >> i) & 8'h1));
         got[i] = ser_dout;
         chk("R8 read-out bit", {31'd0, ser_dout}, {31'd0, logic'((8'hC3 >> i) & 8'h1)});
      end
      chk("R7 R8 byte shifted out", {24'd0, got}, 32'hC3);
      chk("R8 concurrent load", {24'd0, data_o}, 32'h5A);
   endtask

   task automatic t_park();
      set_cw(4'b0011);
      chk("R5 drive+cs before park", {29'd0, pins()}, 32'h3);
      park = 1'b1;
      settle(4);
      chk("R9 pins idle while parked", {29'd0, pins()}, 32'h7);
      chk("R9 data released while parked", {31'd0, data_oe}, 32'h0);
      chk("R9 pin enable off while parked", {31'd0, pins_oe}, 32'h0);
      load(3'b001, 32'hF, 4);
      park = 1'b0;
      settle(4);
      chk("R9 frame ignored while parked", {14'd0, addr_o}, 32'h12396);
      chk("R9 data retained over park", {24'd0, data_o}, 32'h5A);
      apply_cw();
      chk("R9 control word cleared by park", {29'd0, pins()}, 32'h7);
      chk("R9 bus stays released", {31'd0, data_oe}, 32'h0);
   endtask

   task automatic t_collide();
      load(3'b111, 32'h3, 4);
      strobe_low();
      ser_ctrl_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      park = 1'b1;
      @(negedge clk);
      park = 1'b0;
      settle(HALF);
      chk("R11 park beats apply", {29'd0, pins()}, 32'h7);
      chk("R11 bus not driven", {31'd0, data_oe}, 32'h0);
      apply_cw();
      chk("R11 pending word discarded", {29'd0, pins()}, 32'h7);
   endtask

   initial begin
      t_reset();
      t_write();
      t_partial();
      t_bad();
      t_read();
      t_park();
      t_collide();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule